// File: doc/BRIEF.md
# Reconfiguration Port Register Bridge

This block sits between a processor's memory-mapped register port and the dynamic reconfiguration port of a clock-synthesis unit. It holds a reset/enable register that drives the global enable and the synthesizer enable, and a clock-source select register whose index goes straight to a clock multiplexer. It also has a control register and a status register. Together these let software run single read or write accesses on the reconfiguration port.

Software writes one control word that carries a start flag, a read/write flag, the target address and the write data. The bridge then pulses the port enable for one cycle and raises a busy flag, which it clears once the port signals ready. Software polls the status register until busy is low. It may then issue the next control word or collect the returned read data from the low half of the status word. Register requests use a plain valid strobe and are acknowledged one cycle later.

Top module: `cfg_drp_bridge`

## Requirements
- R1: After reset every mapped register reads zero, and the global enable, synthesizer enable, source select and port enable outputs are all low.
- R2: A write to word address 0x10 stores bits 1:0. Bit 0 drives `glob_en` and bit 1 drives `synth_en` from the cycle after the write, and a read of 0x10 returns those two bits with all other bits zero.
- R3: A write to word address 0x11 stores the low SEL_W bits, which drive `src_sel` from the cycle after the write and read back zero-extended.
- R4: A write to word address 0x1C with bit 29 set while not busy starts a transaction. In the next cycle `drp_en` is high for exactly one cycle, `drp_we` equals the inverse of bit 28 (bit 28 set means read), `drp_addr` equals bits 16 and up, and `drp_di` equals bits 15:0. A read of 0x1C returns the last accepted control word.
- R5: Bit 16 of the status word at word address 0x1D reads one from the cycle after an accepted start until the cycle after `drp_rdy` is sampled high, and then reads zero.
- R6: Bits 15:0 of the status word hold the `drp_do` value sampled with `drp_rdy` during a read transaction. They keep that value after busy clears and through later write transactions.
- R7: A control write that arrives while busy produces no port enable, leaves the port address and data outputs unchanged, and leaves the control readback unchanged.
- R8: A control write with bit 29 clear starts nothing: busy stays low, `drp_en` stays low and the control readback is unchanged.
- R9: Every request with `req_valid` high is answered by `req_ack` exactly one cycle later. Read data reflects register contents before that cycle's update, unmapped reads return zero, and writes to unmapped addresses or to the status word change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Register request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 32 | Write data |
| req_ack | output | 1 | Request acknowledge, one cycle after the strobe |
| req_rdata | output | 32 | Read data, valid with `req_ack` |
| glob_en | output | 1 | Global enable / reset release |
| synth_en | output | 1 | Clock-synthesis unit enable |
| src_sel | output | SEL_W | Clock-source index |
| drp_en | output | 1 | Reconfiguration port enable pulse |
| drp_we | output | 1 | Reconfiguration port write enable |
| drp_addr | output | DRP_AW | Reconfiguration port address |
| drp_di | output | DRP_DW | Reconfiguration port write data |
| drp_do | input | DRP_DW | Reconfiguration port read data |
| drp_rdy | input | 1 | Reconfiguration port ready |

## Verification
Each register-port result is due in the cycle after the request: the acknowledge, the read data, the enable and select outputs, and the port enable with its address and data. Busy clears, and read data is captured, in the cycle after ready is sampled. The bench drives every input on the falling edge and samples on the next falling edge. A one-cycle result is therefore seen exactly one rising edge after its cause. The single-cycle width of the enable pulse is checked one falling edge later still. Busy and read data are always checked through status reads issued after the ready pulse has been removed.

// File: rtl/cfg_drp_pkg.sv
package cfg_drp_pkg;
   // Word addresses of the mapped registers
   localparam int unsigned WA_RESET  = 32'h10;
   localparam int unsigned WA_SELECT = 32'h11;
   localparam int unsigned WA_CTRL   = 32'h1C;
   localparam int unsigned WA_STATUS = 32'h1D;
   // Control word field positions
   localparam int unsigned CTL_START_BIT = 29;
   localparam int unsigned CTL_READ_BIT  = 28;
   localparam int unsigned CTL_ADDR_LSB  = 16;
   localparam int unsigned CTL_ADDR_SPAN = 12;
   localparam int unsigned CTL_DATA_SPAN = 16;
   // Status word field positions
   localparam int unsigned STS_BUSY_BIT  = 16;
endpackage

// File: rtl/cfg_drp_regs.sv
module cfg_drp_regs #(
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_reset,
   input  logic             wr_select,
   input  logic [31:0]      wdata,
   output logic             glob_en,
   output logic             synth_en,
   output logic [SEL_W-1:0] src_sel
);
   generate
      if (SEL_W < 1 || SEL_W > 8) begin : g_bad_sel
         $error("SEL_W out of range");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         glob_en  <= 1'b0;
         synth_en <= 1'b0;
         src_sel  <= '0;
      end else begin
         if (wr_reset) begin
            glob_en  <= wdata[0];
            synth_en <= wdata[1];
         end
         if (wr_select) src_sel <= wdata[SEL_W-1:0];
      end
   end

   // R2
   rst_reg_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_reset |=> (glob_en == $past(wdata[0])) && (synth_en == $past(wdata[1])));
   // R3
   sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_select |=> $stable(src_sel));
endmodule

// File: rtl/cfg_drp_engine.sv
module cfg_drp_engine
   import cfg_drp_pkg::*;
#(
   parameter int DRP_AW = 7,
   parameter int DRP_DW = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_wr,
   input  logic [31:0]       wdata,
   output logic              busy,
   output logic [31:0]       ctrl_word,
   output logic [DRP_DW-1:0] rd_data,
   output logic              drp_en,
   output logic              drp_we,
   output logic [DRP_AW-1:0] drp_addr,
   output logic [DRP_DW-1:0] drp_di,
   input  logic [DRP_DW-1:0] drp_do,
   input  logic              drp_rdy
);
   generate
      if (DRP_AW < 1 || DRP_AW > int'(CTL_ADDR_SPAN)) begin : g_bad_aw
         $error("DRP_AW does not fit the control word");
      end
      if (DRP_DW < 1 || DRP_DW > int'(CTL_DATA_SPAN)) begin : g_bad_dw
         $error("DRP_DW does not fit the control word");
      end
   endgenerate

   logic start_ok;
   logic finish;

   assign start_ok = ctrl_wr && wdata[CTL_START_BIT] && !busy;
   assign finish   = busy && drp_rdy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         ctrl_word <= '0;
         rd_data   <= '0;
         drp_en    <= 1'b0;
         drp_we    <= 1'b0;
         drp_addr  <= '0;
         drp_di    <= '0;
      end else begin
         drp_en <= start_ok;
         if (start_ok) begin
            busy      <= 1'b1;
            ctrl_word <= wdata;
            drp_we    <= !wdata[CTL_READ_BIT];
            drp_addr  <= wdata[CTL_ADDR_LSB +: DRP_AW];
            drp_di    <= wdata[DRP_DW-1:0];
         end else if (finish) begin
            busy <= 1'b0;
            if (!drp_we) rd_data <= drp_do;
         end
      end
   end

   // R4
   drp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drp_en |=> !drp_en);
   // R4
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && wdata[CTL_START_BIT] && !busy) |=> (busy && drp_en));
   // R7
   busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ctrl_wr) |=> (!drp_en && $stable(drp_addr) && $stable(drp_di)
                             && $stable(ctrl_word)));
   // R5
   busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && drp_rdy) |=> !busy);
   // R8
   no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !(ctrl_wr && wdata[CTL_START_BIT])) |=> (!busy && !drp_en));
   // R6
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && drp_rdy && !drp_we) |=> $stable(rd_data));
endmodule

// File: rtl/cfg_drp_resp.sv
module cfg_drp_resp
   import cfg_drp_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int SEL_W  = 2,
   parameter int DRP_DW = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              glob_en,
   input  logic              synth_en,
   input  logic [SEL_W-1:0]  src_sel,
   input  logic [31:0]       ctrl_word,
   input  logic              busy,
   input  logic [DRP_DW-1:0] rd_data,
   output logic              req_ack,
   output logic [31:0]       req_rdata
);
   logic [31:0] sel_ext;
   logic [15:0] data_ext;
   logic [31:0] status_word;
   logic [31:0] mux_out;

   generate
      if (SEL_W < 32) begin : g_sel_pad
         assign sel_ext = {{(32-SEL_W){1'b0}}, src_sel};
      end else begin : g_sel_full
         assign sel_ext = src_sel;
      end
      if (DRP_DW < 16) begin : g_data_pad
         assign data_ext = {{(16-DRP_DW){1'b0}}, rd_data};
      end else begin : g_data_full
         assign data_ext = rd_data;
      end
   endgenerate

   assign status_word = {15'b0, busy, data_ext};

   always_comb begin
      mux_out = '0;
      if (32'(req_addr) == WA_RESET)       mux_out = {30'b0, synth_en, glob_en};
      else if (32'(req_addr) == WA_SELECT) mux_out = sel_ext;
      else if (32'(req_addr) == WA_CTRL)   mux_out = ctrl_word;
      else if (32'(req_addr) == WA_STATUS) mux_out = status_word;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_ack   <= 1'b0;
         req_rdata <= '0;
      end else begin
         req_ack   <= req_valid;
         req_rdata <= (req_valid && !req_write) ? mux_out : 32'b0;
      end
   end

   // R9
   ack_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> req_ack);
   // R9
   ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !req_ack);
endmodule

// File: rtl/cfg_drp_bridge.sv
module cfg_drp_bridge
   import cfg_drp_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int SEL_W  = 2,
   parameter int DRP_AW = 7,
   parameter int DRP_DW = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [31:0]       req_wdata,
   output logic              req_ack,
   output logic [31:0]       req_rdata,
   output logic              glob_en,
   output logic              synth_en,
   output logic [SEL_W-1:0]  src_sel,
   output logic              drp_en,
   output logic              drp_we,
   output logic [DRP_AW-1:0] drp_addr,
   output logic [DRP_DW-1:0] drp_di,
   input  logic [DRP_DW-1:0] drp_do,
   input  logic              drp_rdy
);
   generate
      if (ADDR_W < 5 || ADDR_W > 30) begin : g_bad_addr
         $error("ADDR_W cannot reach the register words");
      end
   endgenerate

   logic              wr_stb;
   logic              wr_reset;
   logic              wr_select;
   logic              wr_ctrl;
   logic              busy;
   logic [31:0]       ctrl_word;
   logic [DRP_DW-1:0] rd_data;

   assign wr_stb    = req_valid && req_write;
   assign wr_reset  = wr_stb && (32'(req_addr) == WA_RESET);
   assign wr_select = wr_stb && (32'(req_addr) == WA_SELECT);
   assign wr_ctrl   = wr_stb && (32'(req_addr) == WA_CTRL);

   cfg_drp_regs #(.SEL_W(SEL_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_reset  (wr_reset),
      .wr_select (wr_select),
      .wdata     (req_wdata),
      .glob_en   (glob_en),
      .synth_en  (synth_en),
      .src_sel   (src_sel)
   );

   cfg_drp_engine #(.DRP_AW(DRP_AW), .DRP_DW(DRP_DW)) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl_wr   (wr_ctrl),
      .wdata     (req_wdata),
      .busy      (busy),
      .ctrl_word (ctrl_word),
      .rd_data   (rd_data),
      .drp_en    (drp_en),
      .drp_we    (drp_we),
      .drp_addr  (drp_addr),
      .drp_di    (drp_di),
      .drp_do    (drp_do),
      .drp_rdy   (drp_rdy)
   );

   cfg_drp_resp #(.ADDR_W(ADDR_W), .SEL_W(SEL_W), .DRP_DW(DRP_DW)) u_resp (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_addr  (req_addr),
      .glob_en   (glob_en),
      .synth_en  (synth_en),
      .src_sel   (src_sel),
      .ctrl_word (ctrl_word),
      .busy      (busy),
      .rd_data   (rd_data),
      .req_ack   (req_ack),
      .req_rdata (req_rdata)
   );
endmodule

// File: tb/cfg_drp_bridge_bench.sv
module cfg_drp_bridge_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [5:0]  req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        req_ack;
   logic [31:0] req_rdata;
   logic        glob_en, synth_en;
   logic [1:0]  src_sel;
   logic        drp_en, drp_we;
   logic [6:0]  drp_addr;
   logic [15:0] drp_di;
   logic [15:0] drp_do = '0;
   logic        drp_rdy = 1'b0;

   int n_run = 0;
   int n_fail = 0;

   logic        m_glob = 0, m_syn = 0;
   logic [1:0]  m_sel = 0;
   logic [31:0] m_ctrl = 0;
   logic        m_busy = 0;
   logic [15:0] m_data = 0;

   logic        s_ack, s_en, s_we;
   logic [31:0] s_rd;
   logic [6:0]  s_addr;
   logic [15:0] s_di;

   always #5 clk = ~clk;

   cfg_drp_bridge u_cfg_drp_bridge (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack),
      .req_rdata(req_rdata), .glob_en(glob_en), .synth_en(synth_en),
      .src_sel(src_sel), .drp_en(drp_en), .drp_we(drp_we), .drp_addr(drp_addr),
      .drp_di(drp_di), .drp_do(drp_do), .drp_rdy(drp_rdy)
   );

   function automatic logic [31:0] exp_read(input logic [5:0] a);
      case (a)
         6'h10:   return {30'b0, m_syn, m_glob};
         6'h11:   return {30'b0, m_sel};
         6'h1C:   return m_ctrl;
         6'h1D:   return {15'b0, m_busy, m_data};
         default: return 32'b0;
      endcase
   endfunction

   function automatic logic [31:0] mk_ctrl(input bit start, input bit rd,
                                           input logic [6:0] a, input logic [15:0] d);
      return {2'b0, start, rd, 5'b0, a, d};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus(input bit wr, input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
      s_ack = req_ack; s_rd = req_rdata;
      s_en = drp_en; s_we = drp_we; s_addr = drp_addr; s_di = drp_di;
      chk(s_ack == 1'b1, "R9 ack", {31'b0, s_ack}, 32'd1);
   endtask

   task automatic rd_chk(input logic [5:0] a, input string req);
      bus(1'b0, a, 32'b0);
      chk(s_rd == exp_read(a), req, s_rd, exp_read(a));
   endtask

   task automatic check_all(input string req);
      rd_chk(6'h10, req);
      rd_chk(6'h11, req);
      rd_chk(6'h1C, req);
      rd_chk(6'h1D, req);
   endtask

   task automatic xact(input bit rd, input logic [6:0] a, input logic [15:0] d,
                       input int waitc, input bit poke);
      logic [31:0] w;
      logic [15:0] ret;
      w = mk_ctrl(1'b1, rd, a, d);
      bus(1'b1, 6'h1C, w);
      chk(s_en == 1'b1, "R4 enable pulse", {31'b0, s_en}, 32'd1);
      chk(s_we == !rd, "R4 write enable", {31'b0, s_we}, {31'b0, !rd});
      chk(s_addr == a, "R4 address", {25'b0, s_addr}, {25'b0, a});
      chk(s_di == d, "R4 write data", {16'b0, s_di}, {16'b0, d});
      m_ctrl = w; m_busy = 1'b1;
      @(negedge clk);
      chk(drp_en == 1'b0, "R4 single cycle", {31'b0, drp_en}, 32'd0);
      for (int i = 0; i < waitc; i++) rd_chk(6'h1D, "R5 busy held");
      if (poke) begin
         bus(1'b1, 6'h1C, mk_ctrl(1'b1, !rd, ~a, ~d));
         chk(s_en == 1'b0, "R7 no enable while busy", {31'b0, s_en}, 32'd0);
         chk(s_addr == a, "R7 address held", {25'b0, s_addr}, {25'b0, a});
         rd_chk(6'h1C, "R7 control unchanged");
      end
      ret = 16'($urandom);
      @(negedge clk);
      drp_rdy = 1'b1; drp_do = ret;
      @(negedge clk);
      drp_rdy = 1'b0; drp_do = ~ret;
      m_busy = 1'b0;
      if (rd) m_data = ret;
      rd_chk(6'h1D, rd ? "R6 read data / R5 busy clear" : "R6 data kept / R5 busy clear");
   endtask

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk({glob_en, synth_en, src_sel, drp_en} == 5'b0, "R1 outputs",
          {27'b0, glob_en, synth_en, src_sel, drp_en}, 32'd0);
      check_all("R1 reset reads");
      // R2
      bus(1'b1, 6'h10, 32'hFFFF_FFFF);
      chk({synth_en, glob_en} == 2'b11, "R2 both set", {30'b0, synth_en, glob_en}, 32'd3);
      m_glob = 1; m_syn = 1;
      rd_chk(6'h10, "R2 readback");
      bus(1'b1, 6'h10, 32'h0000_0002);
      chk({synth_en, glob_en} == 2'b10, "R2 synth only", {30'b0, synth_en, glob_en}, 32'd2);
      m_glob = 0;
      // R3
      bus(1'b1, 6'h11, 32'hFFFF_FFFD);
      chk(src_sel == 2'd1, "R3 select out", {30'b0, src_sel}, 32'd1);
      m_sel = 2'd1;
      rd_chk(6'h11, "R3 readback");
      // R9 unmapped and status writes
      bus(1'b1, 6'h00, 32'hFFFF_FFFF);
      bus(1'b1, 6'h1D, 32'hFFFF_FFFF);
      rd_chk(6'h3F, "R9 unmapped read");
      check_all("R9 writes ignored");
      // R8 no start flag
      bus(1'b1, 6'h1C, mk_ctrl(1'b0, 1'b1, 7'h4F, 16'hAAAA));
      chk(s_en == 1'b0, "R8 no enable", {31'b0, s_en}, 32'd0);
      check_all("R8 nothing started");
      // directed transactions
      xact(1'b1, 7'h4F, 16'h0000, 2, 1'b1);
      xact(1'b0, 7'h07, 16'h1234, 0, 1'b0);
      xact(1'b0, 7'h7F, 16'hFFFF, 1, 1'b1);
      check_all("R6 after write");
      // random mix
      for (int it = 0; it < 80; it++) begin
         int op;
         op = int'($urandom_range(0, 3));
         if (op == 0) begin
            logic [31:0] v;
            v = $urandom;
            bus(1'b1, 6'h10, v);
            m_glob = v[0]; m_syn = v[1];
            chk({synth_en, glob_en} == v[1:0], "R2 random", {30'b0, synth_en, glob_en},
                {30'b0, v[1:0]});
         end else if (op == 1) begin
            logic [31:0] v;
            v = $urandom;
            bus(1'b1, 6'h11, v);
            m_sel = v[1:0];
            chk(src_sel == v[1:0], "R3 random", {30'b0, src_sel}, {30'b0, v[1:0]});
         end else if (op == 2) begin
            logic [5:0] a;
            a = 6'($urandom);
            if (a == 6'h10 || a == 6'h11 || a == 6'h1C) a = 6'h1D;
            bus(1'b1, a, $urandom);
            rd_chk(6'($urandom), "R9 random read");
         end else begin
            xact(1'($urandom), 7'($urandom), 16'($urandom),
                 int'($urandom_range(0, 4)), 1'($urandom));
         end
         if (it % 8 == 7) check_all("R9 random sweep");
      end
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule